// File: doc/BRIEF.md
# Programmable One-Shot Timeout Counter

This block is a single-shot timeout timer driven by a 60 MHz device clock. Software programs it by writing one 32-bit control word. Bit 31 of the word arms the timer. Bits 26:0 give the timeout length in device-clock ticks.

While the timer is armed, a private down-counter runs. When that counter runs out, the stored control word clears to zero and the block raises a one-cycle timeout strobe. Masking and combining that strobe with other interrupt sources is left to the logic around the block.

A write with bit 31 set restarts the timer with the new length. A write with bit 31 clear stops the timer quietly, without a strobe.

The control path is a two-state machine:
- **IDLE**: no timeout is pending.
- **ARMED**: the down-counter is running.

Its transitions are:
- **arm write**: IDLE or ARMED to ARMED.
- **cancel write**: IDLE or ARMED to IDLE.
- **countdown**: ARMED to ARMED, while the count is not zero.
- **expiry**: ARMED to IDLE, when the count is zero and no write arrives in that cycle.

Top module: `otg_oneshot_timer`

## Requirements
- R1: After reset, `rd_data` is 0 and `timeout` is low.
- R2: A write stores all 32 bits of `wr_data`. `rd_data` shows the stored word from the cycle after the write. While a timeout is pending, `rd_data` keeps showing the programmed word, not the remaining count.
- R3: A write with bit 31 set and count N in bits 26:0 arms the timer. Counting the write edge as edge 0, `timeout` goes high just after clock edge N+1.
- R4: A write with bit 31 set and count 0 expires on the very next clock edge.
- R5: At expiry, the stored word becomes 0 on the same edge that raises `timeout`. `timeout` stays high for exactly one cycle.
- R6: A write with bit 31 clear cancels any pending timeout. No `timeout` pulse follows that write, and the written word is stored.
- R7: A write with bit 31 set while a timeout is pending replaces it. The only pulse that follows comes N+1 edges after the new write, where N is the new count.
- R8: If a write falls on the edge where expiry would happen, the write wins: no pulse is raised and the written word is stored.
- R9: Bits 30:27 are stored and read back, but they have no effect on the timeout length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word: bit 31 arms the timer, bits 26:0 hold the tick count |
| rd_data | output | 32 | Stored control word; 0 after expiry |
| timeout | output | 1 | One-cycle expiry strobe |

## Verification
The hardest case to reach is a write that lands on exactly the edge where the counter would expire (R8). Missing that edge by one cycle gives either an ordinary expiry or an ordinary cancel.

The stimulus reaches it by arming a short count and then counting falling edges from the end of the arming write, so that the second write is placed on the expiry edge itself. A behavioural model in the bench counts the remaining ticks on its own. Every cycle, the model's read value and strobe are compared with the design's, so an off-by-one in any reload, cancel or countdown path shows up at the cycle where it occurs.

// File: rtl/otg_tmr_pkg.sv
package otg_tmr_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/otg_tmr_reg.sv
// Holds the readable control word: loaded by writes, cleared at expiry.
module otg_tmr_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q <= wr_data;
        end else if (clr) begin
            q <= '0;
        end
    end
endmodule

// File: rtl/otg_tmr_cnt.sv
// Private down-counter, kept separate from the readable word.
module otg_tmr_cnt #(
    parameter int CNT_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/otg_tmr_fsm.sv
// Control state machine: IDLE / ARMED, with a registered expiry strobe.
module otg_tmr_fsm
    import otg_tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_arm,
    input  logic cnt_zero,
    output logic load,
    output logic dec,
    output logic expire,
    output logic timeout
);
    tmr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_en && wr_arm) begin
                    state_d = ST_ARMED;         // arm write
                end
            end
            ST_ARMED: begin
                if (wr_en) begin
                    state_d = wr_arm ? ST_ARMED : ST_IDLE;  // re-arm / cancel
                end else if (cnt_zero) begin
                    state_d = ST_IDLE;          // expiry
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load   = wr_en && wr_arm;
        dec    = 1'b0;
        expire = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ARMED: begin
                dec    = !wr_en;
                expire = !wr_en && cnt_zero;
            end
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timeout <= 1'b0;
        end else begin
            timeout <= expire;
        end
    end
endmodule

// File: rtl/otg_oneshot_timer.sv
module otg_oneshot_timer #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 27,
    parameter int EN_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              timeout
);
    localparam int CNT_MSB = CNT_W - 1;

    logic load, dec, expire, cnt_zero;

    otg_tmr_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_arm   (wr_data[EN_BIT]),
        .cnt_zero (cnt_zero),
        .load     (load),
        .dec      (dec),
        .expire   (expire),
        .timeout  (timeout)
    );

    otg_tmr_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (wr_data[CNT_MSB:0]),
        .dec      (dec),
        .zero     (cnt_zero)
    );

    otg_tmr_reg #(.DATA_W(DATA_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .clr     (expire),
        .q       (rd_data)
    );
endmodule

// File: rtl/otg_oneshot_timer_chk.sv
module otg_oneshot_timer_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 27,
    parameter int EN_BIT = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              timeout
);
    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);

    // R5
    cleared_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (rd_data == '0));

    // R6
    cancel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[EN_BIT]) |=> !timeout);

    // R2
    word_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data == $past(wr_data)));

    // R4
    zero_count_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && $past(wr_en && wr_data[EN_BIT] && (wr_data[CNT_W-1:0] == '0)))
        |=> timeout);
endmodule

bind otg_oneshot_timer otg_oneshot_timer_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .EN_BIT (EN_BIT)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .timeout (timeout)
);

// File: tb/test_otg_oneshot_timer.sv
`timescale 1ns/1ps
module test_otg_oneshot_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        timeout;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    otg_oneshot_timer i_otg_oneshot_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .timeout (timeout)
    );

    // Behavioural reference
    bit          m_armed = 0;
    longint      m_rem   = 0;
    logic [31:0] m_word  = '0;
    bit          m_pulse = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_armed = 0; m_rem = 0; m_word = '0; m_pulse = 0;
        end else if (wr_en) begin
            m_word  = wr_data;
            m_pulse = 0;
            m_armed = wr_data[31];
            m_rem   = longint'(wr_data[26:0]);
        end else if (m_armed) begin
            if (m_rem == 0) begin
                m_armed = 0; m_word = '0; m_pulse = 1;
            end else begin
                m_rem   = m_rem - 1;
                m_pulse = 0;
            end
        end else begin
            m_pulse = 0;
        end
        #1;
        if (!done) begin
            checks++;
            if (rd_data !== m_word) begin
                fails++;
                $display("FAIL R2 rd_data actual=%h expected=%h", rd_data, m_word);
            end
            checks++;
            if (timeout !== m_pulse) begin
                fails++;
                $display("FAIL R3 timeout actual=%0b expected=%0b", timeout, m_pulse);
            end
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Edges from the write edge until a pulse is seen (0 if none)
    task automatic wait_pulse(input int maxc, output int n);
        n = 0;
        for (int i = 1; i <= maxc; i++) begin
            @(posedge clk); #1.5;
            if (timeout) begin n = i; break; end
        end
    endtask

    task automatic count_pulses(input int cyc, output int n);
        n = 0;
        for (int i = 0; i < cyc; i++) begin
            @(posedge clk); #1.5;
            if (timeout) n++;
        end
    endtask

    initial begin
        int n;
        idle(3);
        chk("R1 rd_data in reset", rd_data, 0);
        chk("R1 timeout in reset", timeout, 0);
        rst_n = 1'b1;
        idle(2);
        chk("R1 rd_data after reset", rd_data, 0);

        // R2 / R3: count 100
        wr(32'h8000_0064);
        chk("R2 stored word", rd_data, 32'h8000_0064);
        wait_pulse(300, n);
        chk("R3 expiry edge for N=100", n, 101);
        chk("R5 word cleared at expiry", rd_data, 0);
        @(posedge clk); #1.5;
        chk("R5 pulse one cycle", timeout, 0);

        // R2: readback is programmed word mid-count
        wr(32'h8000_0050);
        idle(30);
        chk("R2 readback not remaining count", rd_data, 32'h8000_0050);
        wait_pulse(200, n);
        chk("R3 expiry edge for N=80 after 30 idle", n, 51);

        // R4: count zero
        wr(32'h8000_0000);
        wait_pulse(10, n);
        chk("R4 zero count fires next edge", n, 1);

        // R6: cancel
        wr(32'h8000_0014);
        idle(5);
        wr(32'h0000_1234);
        count_pulses(40, n);
        chk("R6 no pulse after cancel", n, 0);
        chk("R6 cancel word stored", rd_data, 32'h0000_1234);

        // R7: re-arm replaces pending timeout
        wr(32'h8000_0032);
        idle(10);
        wr(32'h8000_0005);
        wait_pulse(100, n);
        chk("R7 new length used", n, 6);
        count_pulses(60, n);
        chk("R7 old timeout gone", n, 0);

        // R8: write on the expiry edge
        wr(32'h8000_0003);
        idle(2);
        wr(32'h0000_0ABC);
        count_pulses(20, n);
        chk("R8 write beats expiry, no pulse", n, 0);
        chk("R8 written word kept", rd_data, 32'h0000_0ABC);

        // R9: bits 30:27 stored, length unaffected
        wr(32'hF800_0008);
        chk("R9 upper bits stored", rd_data, 32'hF800_0008);
        wait_pulse(50, n);
        chk("R9 length from bits 26:0 only", n, 9);

        idle(5);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        done = 1;
        fails++;
        $display("FAIL R3 watchdog expired: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule